// File: doc/BRIEF.md
# Fifth-Order Sinc Decimator with Boxcar Averaging

This block turns the one-bit stream of an oversampling modulator into multi-bit samples. Each accepted bit is mapped to +1 or -1 and passed through a fifth-order cascaded integrator-comb filter. That filter reduces the rate by a fixed factor of 32. A second stage then adds up a selectable power-of-two number N of consecutive sinc results and divides by N. The final output rate is therefore the modulator rate divided by 32·N. Averaging also puts first-order notches at the final output rate and its integer multiples, which helps reject interferers at known frequencies.

The averaging count is set as a base-two exponent. It is captured at reset and on a restart request. A restart clears every filter register, so a new measurement (for example after an input multiplexer has switched) shares no history with the previous one. Each data-ready pulse carries a settled flag. The flag is high only when every sinc result that went into the average was computed from a window made up entirely of samples taken after the last reset or restart.

Top module: `sinc5_avg_decim`

## Requirements
- R1: With N=1, an input pattern whose period divides 32 and which has ones fraction p gives a settled output of exactly (2p-1)·2^25 (bit 1 counts as +1, bit 0 as -1).
- R2: `data_rdy` is a single-cycle pulse. Consecutive pulses are exactly 32·N accepted samples apart. `filt_out` changes only on a pulse, and `mod_bit` has no effect while `mod_vld` is low.
- R3: With N>1, the output is the sum of N consecutive sinc results shifted arithmetically right by log2(N). For a constant-density input, it therefore equals the N=1 value.
- R4: `avg_log2` = k selects N = 2^k for k = 0 to 6. Code 7 selects N=64.
- R5: `avg_log2` is captured when `rst_n` is low or `restart` is high. Changes at any other time do not alter the output spacing.
- R6: `restart` clears all filter state. The next output is computed only from samples accepted after the restart, and no pulse appears before 32 samples have been accepted.
- R7: Sinc results are counted from 1 after a restart, and averaging windows are aligned to that count. `settled` is high on a pulse exactly when the window's first result has index 5 or more. The first flagged output is therefore at result index 5, 6 and 8 for N = 1, 2 and 4 (5+N-1), and at index 2N for N of 8 or more. The flag stays high on every later pulse.
- R8: After reset, `data_rdy`, `settled` and `filt_out` are all 0.
- R9: `filt_out` never exceeds 2^25 in magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous clear of all filter state; also captures `avg_log2` |
| mod_bit | input | 1 | Modulator output bit |
| mod_vld | input | 1 | Qualifies `mod_bit` for this cycle |
| avg_log2 | input | 3 | Base-two exponent of the averaging count |
| filt_out | output | 27 | Filtered result, signed two's complement |
| data_rdy | output | 1 | One-cycle pulse marking a new `filt_out` |
| settled | output | 1 | Flag accompanying `filt_out`: result is fully settled |

## Verification
The bench builds the block with its default parameters: a decimation of 32 and a largest averaging exponent of 6. With these values, the 2^25 full-scale result, the longest 2048-sample output spacing and the clamping of code 7 are all reachable in a short run. Directed runs cover N = 1, 2, 4, 8 and 64 with periodic bit patterns of known density, sometimes with idle cycles between accepted bits. For each run the bench checks the settled value, the spacing of the pulses, and the exact output at which the settled flag first rises. A restart placed in the middle of a full-scale stream shows that no history is carried over.

// File: rtl/sdm_decim_pkg.sv
// Shared constants for the sinc decimator.
// Assumes: the sinc order is fixed at five; all other sizes come from top parameters.
package sdm_decim_pkg;
    localparam int SINC_ORDER = 5;

    // Growth in bits of the integrator-comb stage for a given decimation exponent.
    function automatic int sinc_growth(input int dec_log2);
        return SINC_ORDER * dec_log2;
    endfunction
endpackage

// File: rtl/sinc_integ_chain.sv
// Cascade of ORDER accumulators running at the input rate.
// Assumes: modular two's-complement arithmetic; wraparound is cancelled by the combs.
// y_next is the value the last accumulator takes at this edge, so a sample
// shows up in it after ORDER-1 earlier samples have propagated.
module sinc_integ_chain #(
    parameter int W     = 27,
    parameter int ORDER = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic signed [W-1:0] x_in,
    output logic signed [W-1:0] y_next
);
    logic signed [W-1:0] acc_q [ORDER];
    logic signed [W-1:0] nxt   [ORDER];

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        if (k == 0) begin : g_first
            // First accumulator sums the mapped input.
            always_comb nxt[k] = acc_q[k] + x_in;
        end else begin : g_rest
            // Later accumulators sum the previous stage's registered value.
            always_comb nxt[k] = acc_q[k] + acc_q[k-1];
        end
        // Accumulator register, cleared by reset or restart.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) acc_q[k] <= '0;
            else if (en)       acc_q[k] <= nxt[k];
        end
    end

    assign y_next = nxt[ORDER-1];
endmodule

// File: rtl/sinc_comb_chain.sv
// Cascade of ORDER first differences running at the decimated rate.
// Assumes: en pulses once per decimation period; differences are taken in one cycle.
module sinc_comb_chain #(
    parameter int W     = 27,
    parameter int ORDER = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic signed [W-1:0] x_in,
    output logic signed [W-1:0] y_out,
    output logic                y_vld
);
    logic signed [W-1:0] c     [ORDER+1];
    logic signed [W-1:0] dly_q [ORDER];

    assign c[0] = x_in;

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        // Difference between this decimated value and the previous one.
        assign c[k+1] = c[k] - dly_q[k];
        // One-sample delay at the decimated rate.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) dly_q[k] <= '0;
            else if (en)       dly_q[k] <= c[k];
        end
    end

    // Output register and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            y_out <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= en;
            if (en) y_out <= c[ORDER];
        end
    end
endmodule

// File: rtl/boxcar_avg.sv
// Sums 2**sel_log2 consecutive input results and shifts the sum right to form the mean.
// Also counts results since restart to flag windows made only of settled results.
// Assumes: sel_log2 <= MAX_LOG2 and is stable between restarts; MAX_LOG2 >= 1.
module boxcar_avg #(
    parameter int IN_W     = 27,
    parameter int MAX_LOG2 = 6,
    parameter int SEL_W    = 3,
    parameter int ORDER    = 5,
    localparam int ACC_W   = IN_W + MAX_LOG2,
    localparam int CNT_MAX = (1 << MAX_LOG2) + ORDER - 1,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   in_vld,
    input  logic signed [IN_W-1:0] in_data,
    input  logic [SEL_W-1:0]       sel_log2,
    output logic signed [IN_W-1:0] dout,
    output logic                   drdy,
    output logic                   settled
);
    logic [MAX_LOG2-1:0]      phase_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_next;
    logic [CNT_W-1:0]         res_cnt_q;
    logic [CNT_W-1:0]         res_cnt_next;
    logic [CNT_W-1:0]         need;
    logic                     last;

    // Window end, sum including this result, count of results including this one.
    always_comb begin
        last         = (phase_q == MAX_LOG2'((32'd1 << sel_log2) - 32'd1));
        acc_next     = ((phase_q == '0) ? '0 : acc_q)
                       + {{MAX_LOG2{in_data[IN_W-1]}}, in_data};
        res_cnt_next = (res_cnt_q == CNT_W'(CNT_MAX)) ? res_cnt_q : res_cnt_q + 1'b1;
        need         = CNT_W'(32'd1 << sel_log2) + CNT_W'(ORDER - 1);
    end

    // Window phase, running sum and result count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q   <= '0;
            acc_q     <= '0;
            res_cnt_q <= '0;
        end else if (in_vld) begin
            phase_q   <= last ? '0 : phase_q + 1'b1;
            acc_q     <= acc_next;
            res_cnt_q <= res_cnt_next;
        end
    end

    // Output word, its pulse and its settled flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dout    <= '0;
            drdy    <= 1'b0;
            settled <= 1'b0;
        end else begin
            drdy <= in_vld && last;
            if (in_vld && last) begin
                dout    <= IN_W'(acc_next >>> sel_log2);
                settled <= (res_cnt_next >= need);
            end
        end
    end
endmodule

// File: rtl/sinc5_avg_decim.sv
// Decimator for a one-bit modulator stream: a fifth-order sinc stage with a fixed rate
// reduction of DEC, followed by a boxcar mean of 2**k sinc results.
// Assumes: DEC is a power of two; the averaging exponent is captured at reset/restart.
module sinc5_avg_decim
    import sdm_decim_pkg::*;
#(
    parameter int DEC          = 32,
    parameter int MAX_AVG_LOG2 = 6,
    localparam int DEC_LOG2    = $clog2(DEC),
    localparam int OUT_W       = 2 + sinc_growth(DEC_LOG2),
    localparam int SEL_W       = $clog2(MAX_AVG_LOG2 + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    mod_bit,
    input  logic                    mod_vld,
    input  logic [SEL_W-1:0]        avg_log2,
    output logic signed [OUT_W-1:0] filt_out,
    output logic                    data_rdy,
    output logic                    settled
);
    logic [DEC_LOG2-1:0]     dec_cnt;
    logic                    dec_evt;
    logic [SEL_W-1:0]        sel_in;
    logic [SEL_W-1:0]        sel_q;
    logic signed [OUT_W-1:0] x_map;
    logic signed [OUT_W-1:0] integ_y;
    logic signed [OUT_W-1:0] sinc_y;
    logic                    sinc_vld;

    // Map the bit to +1/-1, clamp the exponent, detect the decimation instant.
    always_comb begin
        x_map   = mod_bit ? OUT_W'(1) : {OUT_W{1'b1}};
        sel_in  = (avg_log2 > SEL_W'(MAX_AVG_LOG2)) ? SEL_W'(MAX_AVG_LOG2) : avg_log2;
        dec_evt = mod_vld && (&dec_cnt);
    end

    // Capture the averaging exponent only at reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) sel_q <= sel_in;
    end

    // Count accepted samples within one decimation period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) dec_cnt <= '0;
        else if (mod_vld)      dec_cnt <= dec_cnt + 1'b1;
    end

    sinc_integ_chain #(.W(OUT_W), .ORDER(SINC_ORDER)) integ_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .en     (mod_vld),
        .x_in   (x_map),
        .y_next (integ_y)
    );

    sinc_comb_chain #(.W(OUT_W), .ORDER(SINC_ORDER)) comb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (dec_evt),
        .x_in  (integ_y),
        .y_out (sinc_y),
        .y_vld (sinc_vld)
    );

    boxcar_avg #(
        .IN_W     (OUT_W),
        .MAX_LOG2 (MAX_AVG_LOG2),
        .SEL_W    (SEL_W),
        .ORDER    (SINC_ORDER)
    ) avg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .in_vld   (sinc_vld),
        .in_data  (sinc_y),
        .sel_log2 (sel_q),
        .dout     (filt_out),
        .drdy     (data_rdy),
        .settled  (settled)
    );
endmodule

// File: rtl/sinc5_avg_decim_chk.sv
// Property checker for sinc5_avg_decim, attached by bind.
// Assumes: rst_n is synchronous active-low; keeps its own sample and flag history.
module sinc5_avg_decim_chk #(
    parameter int DEC   = 32,
    parameter int OUT_W = 27
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    restart,
    input logic                    mod_vld,
    input logic signed [OUT_W-1:0] filt_out,
    input logic                    data_rdy,
    input logic                    settled
);
    localparam int VC_W = $clog2(DEC + 1);
    localparam logic signed [OUT_W-1:0] LIM = OUT_W'(1) <<< (OUT_W - 2);

    logic [VC_W-1:0] vld_cnt_q;
    logic            seen_q;

    // Accepted samples since reset/restart, saturating at DEC.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)                     vld_cnt_q <= '0;
        else if (mod_vld && vld_cnt_q < VC_W'(DEC)) vld_cnt_q <= vld_cnt_q + 1'b1;
    end

    // Remembers whether a settled output has been seen since reset/restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)      seen_q <= 1'b0;
        else if (data_rdy && settled) seen_q <= 1'b1;
    end

    AST_DRDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |=> !data_rdy); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (data_rdy || $stable(filt_out))); // R2
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!data_rdy && !settled && filt_out == '0)); // R6
    AST_NO_EARLY_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> (vld_cnt_q >= VC_W'(DEC))); // R6
    AST_SETTLED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && seen_q) |-> settled); // R7
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> (filt_out <= LIM && filt_out >= -LIM)); // R9
endmodule

bind sinc5_avg_decim sinc5_avg_decim_chk #(.DEC(DEC), .OUT_W(OUT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .mod_vld  (mod_vld),
    .filt_out (filt_out),
    .data_rdy (data_rdy),
    .settled  (settled)
);

// File: tb/sinc5_avg_decim_tb_top.sv
// Directed bench for sinc5_avg_decim: one task per scenario, each checking its own results.
module sinc5_avg_decim_tb_top;
    localparam longint FS = 64'd33554432; // 2**25

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               restart = 1'b0;
    logic               mod_bit = 1'b0;
    logic               mod_vld = 1'b0;
    logic [2:0]         avg_log2 = 3'd0;
    logic signed [26:0] filt_out;
    logic               data_rdy;
    logic               settled;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;

    longint ev_val [16];
    bit     ev_set [16];
    longint ev_cyc [16];
    int     ev_n = 0;

    sinc5_avg_decim dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .mod_bit  (mod_bit),
        .mod_vld  (mod_vld),
        .avg_log2 (avg_log2),
        .filt_out (filt_out),
        .data_rdy (data_rdy),
        .settled  (settled)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record every output pulse away from the active edge.
    always @(negedge clk) begin
        if (data_rdy) begin
            if (ev_n < 16) begin
                ev_val[ev_n] = longint'(filt_out);
                ev_set[ev_n] = settled;
                ev_cyc[ev_n] = cyc;
            end
            ev_n = ev_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_restart(input int sel);
        @(negedge clk);
        ev_n     = 0;
        mod_vld  = 1'b0;
        avg_log2 = 3'(sel);
        restart  = 1'b1;
        @(negedge clk);
        restart  = 1'b0;
    endtask

    // Feed n accepted samples of a periodic pattern; stride-1 idle cycles carry a flipped bit.
    task automatic feed(input int n, input logic [31:0] pat, input int per, input int stride);
        for (int s = 0; s < n; s++) begin
            mod_vld = 1'b1;
            mod_bit = pat[s % per];
            @(negedge clk);
            for (int g = 1; g < stride; g++) begin
                mod_vld = 1'b0;
                mod_bit = ~pat[s % per];
                @(negedge clk);
            end
        end
        mod_vld = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Restart, stream a constant-density pattern, check values, spacing and settled flags.
    task automatic run_case(input string req, input int sel, input int eff_log2,
                            input logic [31:0] pat, input int per, input int stride);
        int     n    = 1 << eff_log2;
        int     jf   = (2 * n + 3) / n; // first window starting at result 5 (R7)
        int     nout = jf + 2;
        int     ones = 0;
        longint expv;
        for (int b = 0; b < per; b++) ones += int'(pat[b]);
        expv = (longint'(2 * ones - per) * FS) / per;
        do_restart(sel);
        feed(32 * n * nout, pat, per, stride);
        chk(ev_n == nout, "R2", {req, " output count"}, ev_n, nout);
        for (int j = 1; j <= nout && j <= ev_n; j++) begin
            chk(ev_set[j-1] == (j >= jf), "R7", {req, " settled flag"},
                ev_set[j-1], (j >= jf));
            chk(ev_val[j-1] <= FS && ev_val[j-1] >= -FS, "R9", {req, " range"},
                ev_val[j-1], FS);
            if (j >= jf)
                chk(ev_val[j-1] == expv, (n == 1) ? "R1" : "R3", {req, " value"},
                    ev_val[j-1], expv);
            if (j > 1)
                chk(ev_cyc[j-1] - ev_cyc[j-2] == longint'(32 * n * stride), "R4",
                    {req, " spacing"}, ev_cyc[j-1] - ev_cyc[j-2], 32 * n * stride);
        end
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        chk(data_rdy == 1'b0 && settled == 1'b0, "R8", "flags in reset",
            {data_rdy, settled}, 0);
        chk(filt_out == 0, "R8", "output in reset", filt_out, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(ev_n == 0, "R8", "no pulse without samples", ev_n, 0);
    endtask

    // R5: exponent changed without restart must leave the spacing unchanged.
    task automatic t_sel_hold;
        do_restart(0);
        avg_log2 = 3'd3;
        feed(32 * 8, 32'hFFFF_FFFF, 1, 1);
        chk(ev_n == 8, "R5", "pulses after late exponent change", ev_n, 8);
        if (ev_n >= 2)
            chk(ev_cyc[1] - ev_cyc[0] == 32, "R5", "spacing after late change",
                ev_cyc[1] - ev_cyc[0], 32);
    endtask

    // R6: full-scale history before a restart must not leak into later results.
    task automatic t_restart;
        do_restart(0);
        feed(32 * 3 + 7, 32'hFFFF_FFFF, 1, 1);
        run_case("R6 restart mid-stream", 0, 0, 32'h0, 1, 1);
    endtask

    initial begin
        t_reset();
        run_case("R1 N=1 ones", 0, 0, 32'hFFFF_FFFF, 1, 1);
        run_case("R3 N=2 three-in-four gaps", 1, 1, 32'h7, 4, 2);
        run_case("R3 N=4 alternating", 2, 2, 32'h1, 2, 1);
        run_case("R7 N=8 one-in-eight", 3, 3, 32'h1, 8, 1);
        run_case("R4 N=64 ones", 6, 6, 32'hFFFF_FFFF, 1, 1);
        run_case("R4 code7 zeros", 7, 6, 32'h0, 1, 1);
        t_sel_hold();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule